// File: doc/BRIEF.md
# Sequential Shift-and-Add Unsigned Multiplier

This block forms the full-width product of two unsigned operands by repeated shift and add, one step per clock. The multiplicand is held zero-extended in a double-width register that moves one place left on every step. The multiplier is held in a single-width register that moves one place right on every step. A double-width adder always sums the current multiplicand register with the running product. Its result is stored only on steps where the multiplier's lowest bit is set, so each step adds one partial product, or none.

The operand side acts as a single-beat valid/ready port. `start` is the valid. The implicit ready is `!busy`. A beat is accepted on the clock edge where `start` is high and `busy` is low. Nothing queues: a `start` seen while `busy` is high is dropped and cannot stall anything. The result side has no back-pressure. `done` pulses for one cycle when the product is ready, and `product` then holds its value until the next accepted beat.

Top module: `seq_shift_mult`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `product` is 0.
- R2: On the clock edge after an accepted `start` (start=1 while busy=0), `busy` is 1 and `product` is 0.
- R3: `done` rises exactly 32 clock edges after the edge that accepted `start`. At that point `product` equals the unsigned product of the accepted `op_a` and `op_b`, as 64 bits.
- R4: `done` is high for exactly one cycle per operation.
- R5: `busy` stays high from the accepting edge until the edge that raises `done`. `busy` and `done` are never high together.
- R6: While idle, `product` keeps its last value until the next accepted `start`.
- R7: A `start` asserted while `busy` is 1 is ignored. Both the result and the timing of the running operation are unchanged.
- R8: The product register is written on a step only when the multiplier's low bit is 1. With `op_b` = 0, `product` stays 0 on every cycle of the run.
- R9: The largest operands, 0xFFFFFFFF times 0xFFFFFFFF, give 0xFFFFFFFE00000001. No carry beyond 64 bits is kept.
- R10: Changes on `op_a` and `op_b` after the accepting edge have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Operand valid; accepted when busy is low |
| op_a | input | 32 | Multiplicand, sampled on the accepting edge |
| op_b | input | 32 | Multiplier, sampled on the accepting edge |
| busy | output | 1 | High while steps run; its inverse is the operand ready |
| done | output | 1 | One-cycle pulse when the product is final |
| product | output | 64 | Running product, final when done is high |

## Verification
Faults in this block show up at the ports in two ways. A wrong step count or control state moves `done` off its fixed slot, 32 edges after acceptance, and the bench sees this on the exact cycle. A bad shift, a misplaced write enable or a lost operand corrupts `product`. That error appears at the latest when `done` rises. With a zero multiplier it appears on the first step, because the product must stay 0. Mid-run stimulus on `start` and on the operands shows whether a busy unit reloads or samples inputs it should ignore.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic busy,
  output logic done
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  smul_state_e       state;
  logic [CW-1:0]     count;
  logic              last;

  assign busy = (state == ST_RUN);
  assign load = start && (state == ST_IDLE);
  assign step = busy;
  assign last = (count == CW'(W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        state <= ST_RUN;
        count <= '0;
      end else if (state == ST_RUN) begin
        count <= count + CW'(1);
        if (last) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
      end
    end
  end

  // R4: single-cycle completion pulse
  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5: busy and done never overlap
  assert_busy_done_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  // R3: the end of a run always raises done
  assert_fall_gives_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R7: start while running neither restarts nor stops the run
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !last) |=> (busy && count == $past(count) + CW'(1)));
endmodule

// File: rtl/smul_mcand_reg.sv
module smul_mcand_reg #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic [W-1:0]   a_in,
  output logic [2*W-1:0] mcand
);
  localparam int PW = 2 * W;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand <= '0;
    end else if (load) begin
      mcand <= {{(PW - W){1'b0}}, a_in};
    end else if (step) begin
      mcand <= {mcand[PW-2:0], 1'b0};
    end
  end

  // R10: a freshly loaded multiplicand has an empty upper half
  assert_mcand_zext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (mcand[PW-1:W] == '0));
endmodule

// File: rtl/smul_mplier_reg.sv
module smul_mplier_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] b_in,
  output logic         lsb
);
  logic [W-1:0] mplier;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mplier <= '0;
    end else if (load) begin
      mplier <= b_in;
    end else if (step) begin
      mplier <= {1'b0, mplier[W-1:1]};
    end
  end

  assign lsb = mplier[0];

  // R10: while stepping, the multiplier only moves right and never reloads from b_in
  assert_mplier_shift_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (mplier[W-1] == 1'b0));
endmodule

// File: rtl/smul_prod_acc.sv
module smul_prod_acc #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           step,
  input  logic           lsb,
  input  logic [2*W-1:0] mcand,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [PW-1:0] sum;
  logic          wr_en;

  // adder always adds; carry beyond PW bits is dropped
  assign sum   = prod + mcand;
  assign wr_en = step && lsb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod <= '0;
    end else if (load) begin
      prod <= '0;
    end else if (wr_en) begin
      prod <= sum;
    end
  end

  // R8: no write on a step whose multiplier bit is zero
  assert_no_write_on_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !lsb && !load) |=> $stable(prod));
  // R6: idle product holds
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(prod));
  // R2: acceptance clears the product
  assert_clear_on_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (prod == '0));
endmodule

// File: rtl/seq_shift_mult.sv
module seq_shift_mult #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;

  logic          load;
  logic          step;
  logic          lsb;
  logic [PW-1:0] mcand;

  smul_ctrl #(.W(W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .busy  (busy),
    .done  (done)
  );

  smul_mcand_reg #(.W(W)) u_mcand (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .a_in  (op_a),
    .mcand (mcand)
  );

  smul_mplier_reg #(.W(W)) u_mplier (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .b_in  (op_b),
    .lsb   (lsb)
  );

  smul_prod_acc #(.W(W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .lsb   (lsb),
    .mcand (mcand),
    .prod  (product)
  );

  // R2: an idle start is accepted and raises busy on the next edge
  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
endmodule

// File: tb/seq_shift_mult_tb_top.sv
module seq_shift_mult_tb_top;
  localparam int  W      = 32;
  localparam time CLK_PD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  op_a = '0;
  logic [W-1:0]  op_b = '0;
  logic          busy;
  logic          done;
  logic [2*W-1:0] product;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PD / 2) clk = ~clk;

  seq_shift_mult #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
    .busy(busy), .done(done), .product(product)
  );

  function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
    return {32'd0, a} * {32'd0, b};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%016h expected=0x%016h", req, act, exp);
    end
  endtask

  // disturb: 0 none, 1 pulse start with new operands mid-run, 2 change operands only
  task automatic run_mult(input logic [31:0] a, input logic [31:0] b, input int disturb);
    logic [63:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    start = 1'b1; op_a = a; op_b = b;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after accept", 64'(busy), 64'd1);
    chk("R2 product cleared", product, 64'd0);
    for (int j = 1; j <= 32; j++) begin
      if (disturb != 0 && j == 5) begin
        op_a = ~a; op_b = ~b ^ 32'h5A5A_0F0F;
        if (disturb == 1) start = 1'b1;
      end
      if (j == 7) start = 1'b0;
      @(negedge clk);
      if (j < 32) begin
        if (busy !== 1'b1 || done !== 1'b0) begin
          chk("R5/R7 busy held, done low mid-run", {62'd0, busy, done}, 64'd2);
        end
        if (b == 32'd0) begin
          if (product !== 64'd0) chk("R8 zero multiplier keeps product 0", product, 64'd0);
        end
      end
    end
    chk("R3 done on edge 32", 64'(done), 64'd1);
    chk("R5 busy low at done", 64'(busy), 64'd0);
    if (b == 32'd0) chk("R8 zero multiplier", product, 64'd0);
    else if (a == 32'hFFFF_FFFF && b == 32'hFFFF_FFFF) chk("R9 max operands", product, 64'hFFFF_FFFE_0000_0001);
    else if (disturb == 1) chk("R7 start while busy ignored", product, exp);
    else if (disturb == 2) chk("R10 operand change ignored", product, exp);
    else chk("R3 product value", product, exp);
    @(negedge clk);
    chk("R4 done one cycle", 64'(done), 64'd0);
    repeat (2) @(negedge clk);
    chk("R6 product held while idle", product, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    int unsigned seed_val;
    seed_val = $urandom(32'd20240611);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy reset", 64'(busy), 64'd0);
    chk("R1 done reset", 64'(done), 64'd0);
    chk("R1 product reset", product, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {62'd0, busy, done}, 64'd0);

    run_mult(32'd6, 32'd7, 0);
    run_mult(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
    run_mult(32'h1234_5678, 32'd0, 0);
    run_mult(32'd0, 32'hDEAD_BEEF, 0);
    run_mult(32'h8000_0000, 32'h8000_0000, 0);
    run_mult(32'd1, 32'hFFFF_FFFF, 0);
    run_mult(32'hCAFE_F00D, 32'h0000_0003, 1);
    run_mult(32'h0F0F_1234, 32'hA5A5_5A5A, 2);
    run_mult(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1);
    for (int k = 0; k < 24; k++) begin
      run_mult($urandom, $urandom, k % 3);
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule